// File: doc/BRIEF.md
# Pipelined Tag Memory with Registered Compare

This block is a small synchronous tag store for a cache controller. Each entry holds an 18-bit word made of two 9-bit bytes. Every control, address and data input is captured on the rising clock edge. The word at the registered address is read out through an output register. In the same cycle that word is compared with a separately loaded input-data register, and the compare result is captured in its own pipeline register. A controller loads a tag with a byte write or a whole-word write, then presents a candidate tag and watches the hit flag one clock later.

An address is accepted by one of two start strobes: a processor-side strobe that works only while the primary select is active, and a controller-side strobe. Three chip selects allow depth expansion. An advance input then steps the two low address bits, either in linear order or in interleaved (XOR) order. The two outputs follow pad-style drive rules: each comes with a drive-enable bit gated by its own active-low output enable and by a select state that is delayed one cycle. A disabled output reads as zero.

Top module: `tag_match_ram`

## Requirements
- R1: When `ctrl_strobe_n` is low at edge k, the address is latched. If the chip is selected and `q_oe_n` is low, `q_out` shows the word stored at that address after edge k+1, with `q_drive` high.
- R2: The data register loads `din` only at an edge where `din_load_n` is low, `sel_n` is low, `sel_hi` is high and `sel_lo_n` is low. At every other edge it keeps its value.
- R3: After edge k+1, `hit_out` is 1 exactly when the data register held during cycle k equals the word stored at the address registered for that cycle.
- R4: `q_drive` equals the delayed select ANDed with the inverse of `q_oe_n`, and `hit_drive` does the same with `hit_oe_n`. Both are combinational, and an output whose drive bit is low reads all zeros.
- R5: When `byte_wr_en_n` is low, `byte_we_n[0]` low writes bits 8:0 and `byte_we_n[1]` low writes bits 17:9. When `byte_wr_en_n` is high, these two inputs write nothing.
- R6: When `all_wr_n` is low, both bytes are written, whatever `byte_wr_en_n` and `byte_we_n` are.
- R7: `proc_strobe_n` is ignored while `sel_n` is high. When both strobes are low it takes priority. A cycle started by it writes nothing.
- R8: With `burst_ilv` = 0, each edge with `adv_n` low and no strobe adds 1, modulo 4, to the two low address bits, counting from the latched base.
- R9: With `burst_ilv` = 1, the two low address bits are the latched base XOR a count that goes 0, 1, 2, 3.
- R10: A strobe taken while any of the three selects is inactive deselects the chip. After the following edge, `q_drive` and `hit_drive` are low, and writes and address advance have no effect on the stored words.
- R11: A write and a compare or read of the same entry in the same cycle see the old contents. The new word appears from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| addr_in | input | ADDR_W | Entry address |
| din | input | 18 | Write and compare data |
| sel_n | input | 1 | Primary select, active low |
| sel_hi | input | 1 | Expansion select, active high |
| sel_lo_n | input | 1 | Expansion select, active low |
| proc_strobe_n | input | 1 | Processor-side address start, active low |
| ctrl_strobe_n | input | 1 | Controller-side address start, active low |
| adv_n | input | 1 | Burst advance, active low |
| byte_we_n | input | 2 | Per-byte write strobes, active low |
| byte_wr_en_n | input | 1 | Qualifier for byte writes, active low |
| all_wr_n | input | 1 | Whole-word write, active low |
| din_load_n | input | 1 | Data register load enable, active low |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| q_oe_n | input | 1 | Read data output enable, active low |
| hit_oe_n | input | 1 | Hit output enable, active low |
| q_out | output | 18 | Registered read word, zero when not driven |
| q_drive | output | 1 | Read data drive enable |
| hit_out | output | 1 | Registered compare result, zero when not driven |
| hit_drive | output | 1 | Hit drive enable |

## Verification
The assertions assume that every input is a known value from the release of reset onward. They also assume that `burst_ilv` and the two output enables change only between clock edges, so a value is never seen on both sides of an edge. The bench changes every input on the falling edge only. It picks random values under biases that keep strobes rare and the selects mostly active, so bursts and writes run long enough to reach the counter wrap. Directed runs cover the same-entry write-and-compare ordering and the ignored processor strobe.

// File: rtl/tagram_pkg.sv
package tagram_pkg;
  localparam int BURST_W = 2;
  typedef logic [BURST_W-1:0] burst_t;

  // low address bits of a burst beat: linear sum or interleaved XOR
  function automatic burst_t burst_low(burst_t base, burst_t cnt, logic ilv);
    burst_t sum;
    sum = base + cnt;
    return ilv ? (base ^ cnt) : sum;
  endfunction
endpackage

// File: rtl/tagram_addr_ctl.sv
module tagram_addr_ctl
  import tagram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              sel_n,
  input  logic              sel_hi,
  input  logic              sel_lo_n,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              adv_n,
  input  logic              burst_ilv,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              sel_q,
  output logic              sel_next,
  output logic              proc_start,
  output logic              strobe,
  output logic              en_all
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic [HI_W-1:0] hi_q;
  burst_t          base_q, cnt_q;

  // named events
  assign en_all     = !sel_n && sel_hi && !sel_lo_n;
  assign proc_start = !proc_strobe_n && !sel_n;
  assign strobe     = proc_start || !ctrl_strobe_n;
  assign sel_next   = strobe ? en_all : sel_q;
  assign eff_addr   = {hi_q, burst_low(base_q, cnt_q, burst_ilv)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
    end else begin
      sel_q <= sel_next;
      if (strobe) begin
        hi_q   <= addr_in[ADDR_W-1:BURST_W];
        base_q <= addr_in[BURST_W-1:0];
        cnt_q  <= '0;
      end else if (!adv_n) begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  a_r1_strobe_latch: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (hi_q == $past(addr_in[ADDR_W-1:BURST_W]) &&
                base_q == $past(addr_in[BURST_W-1:0]) && cnt_q == '0));

  a_r7_proc_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strobe_n && sel_n && ctrl_strobe_n) |=> ($stable(hi_q) && $stable(base_q)));

  a_r8_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !adv_n) |=> (cnt_q == $past(cnt_q) + 2'd1));
endmodule

// File: rtl/tagram_store.sv
module tagram_store #(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NBYTES*BYTE_W-1:0] wr_data,
  input  logic                     wr_ok,
  input  logic                     all_wr_n,
  input  logic                     byte_wr_en_n,
  input  logic [NBYTES-1:0]        byte_we_n,
  input  logic                     proc_start,
  output logic [NBYTES*BYTE_W-1:0] rd_word
);
  localparam int DATA_W = NBYTES * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [NBYTES-1:0] wr_mask_q;

  // whole-word write overrides, byte strobes need their qualifier
  function automatic logic [NBYTES-1:0] byte_mask(logic gw_n, logic bw_n,
                                                 logic [NBYTES-1:0] we_n);
    if (!gw_n)      return '1;
    else if (!bw_n) return ~we_n;
    else            return '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) wr_mask_q <= '0;
    else        wr_mask_q <= wr_ok ? byte_mask(all_wr_n, byte_wr_en_n, byte_we_n) : '0;
  end

  assign rd_word = mem[addr];

  // read path sees the old word; update lands at the edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int b = 0; b < NBYTES; b++)
        if (wr_mask_q[b]) mem[addr][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
    end
  end

  a_r7_proc_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    proc_start |=> (wr_mask_q == '0));

  a_r6_global_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !all_wr_n) |=> (wr_mask_q == '1));
endmodule

// File: rtl/tagram_cmp.sv
module tagram_cmp #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              din_load_n,
  input  logic              en_all,
  input  logic [DATA_W-1:0] rd_word,
  input  logic              sel_q,
  output logic [DATA_W-1:0] din_q,
  output logic [DATA_W-1:0] q_q,
  output logic              hit_q,
  output logic              osel_q
);
  logic load_ev, eq_ev;
  assign load_ev = !din_load_n && en_all;
  assign eq_ev   = (din_q == rd_word);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      din_q  <= '0;
      q_q    <= '0;
      hit_q  <= 1'b0;
      osel_q <= 1'b0;
    end else begin
      if (load_ev) din_q <= din;
      q_q    <= rd_word;
      hit_q  <= eq_ev;
      osel_q <= sel_q;
    end
  end

  a_r2_din_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ev |=> $stable(din_q));
endmodule

// File: rtl/tag_match_ram.sv
module tag_match_ram #(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr_in,
  input  logic [NBYTES*BYTE_W-1:0] din,
  input  logic                     sel_n,
  input  logic                     sel_hi,
  input  logic                     sel_lo_n,
  input  logic                     proc_strobe_n,
  input  logic                     ctrl_strobe_n,
  input  logic                     adv_n,
  input  logic [NBYTES-1:0]        byte_we_n,
  input  logic                     byte_wr_en_n,
  input  logic                     all_wr_n,
  input  logic                     din_load_n,
  input  logic                     burst_ilv,
  input  logic                     q_oe_n,
  input  logic                     hit_oe_n,
  output logic [NBYTES*BYTE_W-1:0] q_out,
  output logic                     q_drive,
  output logic                     hit_out,
  output logic                     hit_drive
);
  localparam int DATA_W = NBYTES * BYTE_W;

  logic [ADDR_W-1:0] eff_addr;
  logic              sel_q, sel_next, proc_start, strobe, en_all, wr_ok;
  logic [DATA_W-1:0] rd_word, din_q, q_q;
  logic              hit_q, osel_q;

  tagram_addr_ctl #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .sel_n(sel_n), .sel_hi(sel_hi),
    .sel_lo_n(sel_lo_n), .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
    .adv_n(adv_n), .burst_ilv(burst_ilv), .eff_addr(eff_addr), .sel_q(sel_q),
    .sel_next(sel_next), .proc_start(proc_start), .strobe(strobe), .en_all(en_all));

  assign wr_ok = sel_next && !proc_start;

  tagram_store #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .addr(eff_addr), .wr_data(din_q), .wr_ok(wr_ok),
    .all_wr_n(all_wr_n), .byte_wr_en_n(byte_wr_en_n), .byte_we_n(byte_we_n),
    .proc_start(proc_start), .rd_word(rd_word));

  tagram_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .din(din), .din_load_n(din_load_n), .en_all(en_all),
    .rd_word(rd_word), .sel_q(sel_q), .din_q(din_q), .q_q(q_q), .hit_q(hit_q),
    .osel_q(osel_q));

  // pad-style drive: enable bit plus value forced to zero when idle
  assign q_drive   = osel_q && !q_oe_n;
  assign hit_drive = osel_q && !hit_oe_n;
  assign q_out     = q_drive ? q_q : '0;
  assign hit_out   = hit_drive && hit_q;

  a_r10_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !en_all) |=> ##1 (!q_drive && !hit_drive));
endmodule

// File: tb/sim_tag_match_ram.sv
module sim_tag_match_ram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 18;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr_in;
  logic [DW-1:0] din;
  logic sel_n, sel_hi, sel_lo_n, proc_strobe_n, ctrl_strobe_n, adv_n;
  logic [1:0] byte_we_n;
  logic byte_wr_en_n, all_wr_n, din_load_n, burst_ilv, q_oe_n, hit_oe_n;
  logic [DW-1:0] q_out;
  logic q_drive, hit_out, hit_drive;

  int checks = 0, fails = 0;

  // bench reference state
  logic [DW-1:0] m_mem [64];
  logic [DW-1:0] m_dreg, m_q;
  logic [3:0] m_hi;
  logic [1:0] m_base, m_cnt, m_wmask;
  logic m_sel, m_osel, m_hit;

  always #(CLK_PERIOD/2) clk = ~clk;

  tag_match_ram u0 (.*);

  function automatic logic [AW-1:0] ref_addr();
    logic [1:0] lo;
    lo = burst_ilv ? (m_base ^ m_cnt) : 2'(m_base + m_cnt);
    return {m_hi, lo};
  endfunction

  function automatic logic [1:0] ref_mask(logic gw_n, logic bw_n, logic [1:0] we_n);
    logic [1:0] m;
    m = 2'b00;
    if (!bw_n) m = ~we_n;
    if (!gw_n) m = 2'b11;
    return m;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [AW-1:0] a;
    logic [DW-1:0] w;
    logic ps, st, en3, ns;
    a = ref_addr();
    w = m_mem[a];
    m_q = w; m_hit = (m_dreg == w); m_osel = m_sel;
    if (m_wmask[0]) w[8:0]  = m_dreg[8:0];
    if (m_wmask[1]) w[17:9] = m_dreg[17:9];
    m_mem[a] = w;
    en3 = !sel_n && sel_hi && !sel_lo_n;
    ps  = !proc_strobe_n && !sel_n;
    st  = ps || !ctrl_strobe_n;
    ns  = st ? en3 : m_sel;
    if (st) begin m_hi = addr_in[5:2]; m_base = addr_in[1:0]; m_cnt = 2'd0; end
    else if (!adv_n) m_cnt = m_cnt + 2'd1;
    m_wmask = (ns && !ps) ? ref_mask(all_wr_n, byte_wr_en_n, byte_we_n) : 2'b00;
    if (!din_load_n && en3) m_dreg = din;
    m_sel = ns;
  endtask

  task automatic compare_outs(string tag);
    logic qd, hd;
    qd = m_osel && !q_oe_n;
    hd = m_osel && !hit_oe_n;
    check({tag, " R4 q_drive"}, 32'(q_drive), 32'(qd));
    check({tag, " R4 hit_drive"}, 32'(hit_drive), 32'(hd));
    check({tag, " R1 q_out"}, 32'(q_out), qd ? 32'(m_q) : 32'd0);
    check({tag, " R3 hit_out"}, 32'(hit_out), 32'(hd && m_hit));
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_outs(tag);
  endtask

  task automatic idle();
    proc_strobe_n = 1; ctrl_strobe_n = 1; adv_n = 1; byte_we_n = 2'b11;
    byte_wr_en_n = 1; all_wr_n = 1; din_load_n = 1;
    sel_n = 0; sel_hi = 1; sel_lo_n = 0; q_oe_n = 0; hit_oe_n = 0;
  endtask

  task automatic start_at(logic [AW-1:0] a);
    idle(); ctrl_strobe_n = 0; addr_in = a;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    addr_in = '0; din = '0; burst_ilv = 0; idle();
    for (int i = 0; i < 64; i++) m_mem[i] = '0;
    m_dreg = '0; m_q = '0; m_hi = '0; m_base = '0; m_cnt = '0; m_wmask = '0;
    m_sel = 0; m_osel = 0; m_hit = 0;
    repeat (3) @(negedge clk);
    check("R4 reset q_drive", 32'(q_drive), 0);
    check("R4 reset hit_drive", 32'(hit_drive), 0);
    check("R4 reset q_out", 32'(q_out), 0);
    rst_n = 1;

    // R11: write E to entry 5, then D with the same entry compared in the write cycle
    start_at(6'd5); din = 18'h0AAAA; din_load_n = 0; all_wr_n = 0; cyc("R6 write");
    idle(); cyc("R6 settle"); cyc("R6 settle");
    start_at(6'd5); din = 18'h15555; din_load_n = 0; all_wr_n = 0; cyc("R11 setup");
    idle(); cyc("R11 same-cycle");
    check("R11 old word read", 32'(q_out), 32'h0AAAA);
    check("R11 old word compared", 32'(hit_out), 0);
    cyc("R11 next cycle");
    check("R11 new word read", 32'(q_out), 32'h15555);
    check("R3 hit on new word", 32'(hit_out), 1);

    // R5: upper byte only, with and without qualifier
    start_at(6'd5); din = 18'h3FFFF; din_load_n = 0; byte_we_n = 2'b01; byte_wr_en_n = 0;
    cyc("R5 upper byte"); idle(); cyc("R5"); cyc("R5");
    check("R5 upper byte only", 32'(q_out), 32'h3FF55);
    start_at(6'd5); byte_we_n = 2'b00; byte_wr_en_n = 1; din = 18'h0; din_load_n = 0;
    cyc("R5 unqualified"); idle(); cyc("R5"); cyc("R5");
    check("R5 no write without qualifier", 32'(q_out), 32'h3FF55);

    // R7: processor strobe with primary select inactive is ignored
    idle(); proc_strobe_n = 0; sel_n = 1; addr_in = 6'd20; cyc("R7 ignored");
    idle(); cyc("R7"); check("R7 address kept", 32'(q_out), 32'h3FF55);
    // R7: both strobes and a write: processor strobe wins, no write
    idle(); proc_strobe_n = 0; ctrl_strobe_n = 0; addr_in = 6'd5; all_wr_n = 0;
    din = 18'h12345; din_load_n = 0; cyc("R7 priority");
    idle(); cyc("R7"); cyc("R7");
    check("R7 no write in processor cycle", 32'(q_out), 32'h3FF55);

    // R8 / R9: bursts from base 2 in both orders
    for (int m = 0; m < 2; m++) begin
      burst_ilv = m[0];
      start_at(6'd10); cyc(m ? "R9 burst" : "R8 burst");
      for (int k = 0; k < 6; k++) begin
        idle(); adv_n = 0; all_wr_n = 0; din_load_n = 0; din = 18'(k * 7 + m);
        cyc(m ? "R9 burst" : "R8 burst");
      end
      idle(); cyc("R8 R9 drain");
    end

    // R10: deselect via strobe with an expansion select inactive
    start_at(6'd3); sel_hi = 0; cyc("R10 deselect"); idle(); cyc("R10");
    check("R10 q_drive low", 32'(q_drive), 0);
    check("R10 hit_drive low", 32'(hit_drive), 0);

    // constrained random traffic against the bench model
    void'($urandom(32'd20240611));
    for (int n = 0; n < 3000; n++) begin
      addr_in = 6'($urandom); din = 18'($urandom % 4 == 0 ? m_dreg : $urandom);
      sel_n = ($urandom % 10) == 0; sel_hi = ($urandom % 10) != 0;
      sel_lo_n = ($urandom % 10) == 0;
      proc_strobe_n = ($urandom % 10) != 0; ctrl_strobe_n = ($urandom % 7) != 0;
      adv_n = ($urandom % 5) < 3; byte_we_n = 2'($urandom);
      byte_wr_en_n = ($urandom % 3) != 0; all_wr_n = ($urandom % 8) != 0;
      din_load_n = $urandom % 2; burst_ilv = ($urandom % 5) == 0;
      q_oe_n = ($urandom % 5) == 0; hit_oe_n = ($urandom % 5) == 0;
      cyc("R2 R3 R8 R9 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule